// File: doc/BRIEF.md
# Strap-Captured Clock Buffer Control Registers

This block is the configuration store for a multi-output clock buffer. On the first clock after power-on it copies four strap pin levels into a mode byte. These are the spread amount, the spread enable and the path select between plain fan-out and the spread generator. Until software takes over, the buffer's spread controls follow the strap pins live. A host writes a control-source bit to move those functions onto the register bits, and that handover lasts until the next power-on.

The same register space holds a per-output enable byte and a per-output stop-mode byte. Each output's run signal combines its enable bit with its external OE pin. An output in free-running mode ignores its pin. Two more mode bits tell the surrounding pads whether the power-down and stop lines are driven or left high-impedance. Access is a plain byte-addressed port: address, write data, write strobe, and combinational read data.

Two resets reach the block. `por_n` is the power-on reset. It clears every register, including the capture flag and the source-select state. `rst_n` is a warm reset. It restores the host-owned fields to their defaults and leaves the captured strap values and the source selection untouched.

Top module: `clkbuf_cfg_regs`

## Requirements
- R1: On the first clock edge with both `por_n` and `rst_n` high after a power-on reset, address 0 bits [4:3] load `strap_amt`, bit 2 loads `strap_ss_en` and bit 1 loads `strap_sscg_path`.
- R2: After that capture, address 0 bits [4:1] never follow the strap pins again, including through any number of warm resets; only `por_n` re-arms the capture.
- R3: While address 0 bit 0 is 1 (its value after power-on), `eff_amt`, `eff_ss_en` and `eff_sscg_path` follow the live strap pins in the same cycle.
- R4: A write to address 0 with bit 0 = 0 also loads bits [4:1] from that write. From then on the effective spread outputs equal the stored bits and do not react to the strap pins.
- R5: Once address 0 bit 0 is 0 it stays 0 until the next power-on reset; writing 1 to it has no effect.
- R6: A write to address 0 that leaves bit 0 at 1 while bit 0 is still 1 does not change bits [4:1], but it does store bits [7:5].
- R7: Address 0 bit 7 drives `pwrdn_hiz` and bit 6 drives `stop_hiz` (1 = high-impedance, 0 = driven), and both are 0 after either reset.
- R8: For each implemented lane i, `out_run[i]` = address 1 bit i AND (NOT address 2 bit i OR `oe_pin[i]`); unimplemented lanes hold `out_run[i]` at 0.
- R9: After either reset, address 1 reads 0xFF, address 2 reads 0x00 and address 0 bits [7:5] read 0. Every bit of addresses 1 and 2 is writable and reads back.
- R10: Addresses 3 and above read 0, and writes to them change nothing that is readable.
- R11: A write presented on the capture cycle itself is ignored at every address.
- R12: A read of address 0 returns the stored bits [4:1], never the live strap levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; re-arms strap capture |
| rst_n | input | 1 | Warm reset, active low, asynchronous; host fields only |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per clock |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| strap_amt | input | 2 | Spread amount strap: 00 -0.125 %, 01 -0.25 %, 10 -0.375 %, 11 -0.50 % |
| strap_ss_en | input | 1 | Spread enable strap |
| strap_sscg_path | input | 1 | Path strap: 1 spread path, 0 plain fan-out |
| oe_pin | input | LANES | Per-output enable pins, active high |
| out_run | output | LANES | Per-output run gate |
| eff_amt | output | 2 | Effective spread amount code |
| eff_ss_en | output | 1 | Effective spread enable |
| eff_sscg_path | output | 1 | Effective path select |
| pwrdn_hiz | output | 1 | Power-down line mode: 1 high-impedance |
| stop_hiz | output | 1 | Stop line mode: 1 high-impedance |

## Verification
Any wrong stored bit shows at a port in the very next cycle. Every field can be read combinationally at its address, and the effective outputs and run gates are combinational functions of the stored state. A capture flag stuck high or low shows as the wrong address 0 value one clock after reset release, or as a host write that is accepted on the capture cycle. A wrong source-select bit shows as effective spread outputs that follow, or fail to follow, a strap change in the same cycle as that change. For that reason the reference model is compared against every output on every clock while the straps move.

// File: rtl/clkbuf_cfg_pkg.sv
package clkbuf_cfg_pkg;

   // register byte addresses
   localparam int ADDR_MODE = 0;
   localparam int ADDR_EN   = 1;
   localparam int ADDR_STOP = 2;

   // mode byte bit positions
   localparam int MB_PD_HIZ   = 7;
   localparam int MB_STOP_HIZ = 6;
   localparam int MB_UP_LO    = 5;
   localparam int MB_FLD_HI   = 4;
   localparam int MB_FLD_LO   = 1;
   localparam int MB_SRC      = 0;

   localparam int UP_W  = MB_PD_HIZ - MB_UP_LO + 1;
   localparam int FLD_W = MB_FLD_HI - MB_FLD_LO + 1;

   // spread configuration, packed in mode-byte order (amt at [4:3])
   typedef struct packed {
      logic [1:0] amt;
      logic       ss_en;
      logic       sscg_path;
   } spread_cfg_t;

endpackage

// File: rtl/cfg_byte_reg.sv
module cfg_byte_reg #(
   parameter int              W   = 8,
   parameter logic [W-1:0]    RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("cfg_byte_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST;
      end else if (we) begin
         q <= d;
      end
   end

endmodule

// File: rtl/cfg_strap_src.sv
module cfg_strap_src
   import clkbuf_cfg_pkg::*;
(
   input  logic         clk,
   input  logic         por_n,
   input  logic         rst_n,
   input  spread_cfg_t  strap_i,
   input  logic         wr_i,
   input  logic [MB_FLD_HI:0] wdata_i,
   output logic         captured_o,
   output logic         src_pins_o,
   output spread_cfg_t  field_o,
   output logic         fld_wr_o
);

   logic        captured_q;
   logic        src_pins_q;
   spread_cfg_t field_q;
   logic        take_write;

   assign take_write = rst_n && captured_q && wr_i;
   // field accepts data once the source is the register, or in the write that hands it over
   assign fld_wr_o   = take_write && (!src_pins_q || !wdata_i[MB_SRC]);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         captured_q <= 1'b0;
         src_pins_q <= 1'b1;
         field_q    <= '0;
      end else if (rst_n) begin
         if (!captured_q) begin
            captured_q <= 1'b1;
            field_q    <= strap_i;
         end else begin
            if (fld_wr_o) begin
               field_q <= spread_cfg_t'(wdata_i[MB_FLD_HI:MB_FLD_LO]);
            end
            if (take_write) begin
               src_pins_q <= src_pins_q & wdata_i[MB_SRC];
            end
         end
      end
   end

   assign captured_o = captured_q;
   assign src_pins_o = src_pins_q;
   assign field_o    = field_q;

   // R1
   cap_load_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(captured_q) |-> (field_q == $past(strap_i)));

   // R2
   field_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (captured_q && $past(captured_q) && !$past(fld_wr_o)) |-> $stable(field_q));

   // R5
   src_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      !src_pins_q |=> !src_pins_q);

endmodule

// File: rtl/cfg_out_gate.sv
module cfg_out_gate #(
   parameter int               LANES = 8,
   parameter logic [LANES-1:0] MASK  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] en,
   input  logic [LANES-1:0] stop,
   input  logic [LANES-1:0] oe,
   output logic [LANES-1:0] run
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (MASK[i]) begin : g_impl
         assign run[i] = en[i] & (~stop[i] | oe[i]);

         // R8
         run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            run[i] |-> (en[i] && (oe[i] || !stop[i])));
      end else begin : g_absent
         assign run[i] = 1'b0;
      end
   end

endmodule

// File: rtl/clkbuf_cfg_regs.sv
module clkbuf_cfg_regs
   import clkbuf_cfg_pkg::*;
#(
   parameter int               ADDR_W   = 3,
   parameter int               LANES    = 8,
   parameter logic [LANES-1:0] OUT_MASK = 8'h66,
   parameter logic [7:0]       EN_RST   = 8'hFF,
   parameter logic [7:0]       STOP_RST = 8'h00
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   output logic [7:0]        reg_rdata,
   input  logic [1:0]        strap_amt,
   input  logic              strap_ss_en,
   input  logic              strap_sscg_path,
   input  logic [LANES-1:0]  oe_pin,
   output logic [LANES-1:0]  out_run,
   output logic [1:0]        eff_amt,
   output logic              eff_ss_en,
   output logic              eff_sscg_path,
   output logic              pwrdn_hiz,
   output logic              stop_hiz
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("clkbuf_cfg_regs: ADDR_W must reach address 3");
   end
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("clkbuf_cfg_regs: LANES must be 1..8");
   end

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_EN);
   localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(ADDR_STOP);

   logic            warm_rst_n;
   logic            cap_done;
   logic            src_pins;
   logic            fld_wr;
   logic            wr_ok;
   spread_cfg_t     strap_cfg;
   spread_cfg_t     field;
   spread_cfg_t     eff_cfg;
   logic [UP_W-1:0] up_q;
   logic [7:0]      en_q;
   logic [7:0]      stop_q;

   assign warm_rst_n = rst_n & por_n;
   // host writes wait until the strap capture has happened
   assign wr_ok      = reg_we & cap_done;

   assign strap_cfg = '{amt: strap_amt, ss_en: strap_ss_en, sscg_path: strap_sscg_path};

   cfg_strap_src u_src (
      .clk        (clk),
      .por_n      (por_n),
      .rst_n      (rst_n),
      .strap_i    (strap_cfg),
      .wr_i       (wr_ok && (reg_addr == A_MODE)),
      .wdata_i    (reg_wdata[MB_FLD_HI:0]),
      .captured_o (cap_done),
      .src_pins_o (src_pins),
      .field_o    (field),
      .fld_wr_o   (fld_wr)
   );

   cfg_byte_reg #(.W(UP_W), .RST('0)) u_mode_up (
      .clk   (clk),
      .rst_n (warm_rst_n),
      .we    (wr_ok && (reg_addr == A_MODE)),
      .d     (reg_wdata[MB_PD_HIZ:MB_UP_LO]),
      .q     (up_q)
   );

   cfg_byte_reg #(.W(8), .RST(EN_RST)) u_en (
      .clk   (clk),
      .rst_n (warm_rst_n),
      .we    (wr_ok && (reg_addr == A_EN)),
      .d     (reg_wdata),
      .q     (en_q)
   );

   cfg_byte_reg #(.W(8), .RST(STOP_RST)) u_stop (
      .clk   (clk),
      .rst_n (warm_rst_n),
      .we    (wr_ok && (reg_addr == A_STOP)),
      .d     (reg_wdata),
      .q     (stop_q)
   );

   cfg_out_gate #(.LANES(LANES), .MASK(OUT_MASK)) u_gate (
      .clk   (clk),
      .rst_n (warm_rst_n),
      .en    (en_q[LANES-1:0]),
      .stop  (stop_q[LANES-1:0]),
      .oe    (oe_pin),
      .run   (out_run)
   );

   assign eff_cfg       = src_pins ? strap_cfg : field;
   assign eff_amt       = eff_cfg.amt;
   assign eff_ss_en     = eff_cfg.ss_en;
   assign eff_sscg_path = eff_cfg.sscg_path;
   assign pwrdn_hiz     = up_q[MB_PD_HIZ - MB_UP_LO];
   assign stop_hiz      = up_q[MB_STOP_HIZ - MB_UP_LO];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_MODE) begin
         reg_rdata = {up_q, field, src_pins};
      end else if (reg_addr == A_EN) begin
         reg_rdata = en_q;
      end else if (reg_addr == A_STOP) begin
         reg_rdata = stop_q;
      end
   end

   // R4
   eff_pin_isolate_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!src_pins && $past(!src_pins) && !$past(fld_wr))
         |-> $stable({eff_amt, eff_ss_en, eff_sscg_path}));

   // R11
   cap_write_block_chk: assert property (@(posedge clk) disable iff (!warm_rst_n)
      !cap_done |=> ($stable(en_q) && $stable(stop_q) && $stable(up_q)));

endmodule

// File: tb/tb_clkbuf_cfg_regs.sv
module tb_clkbuf_cfg_regs;

   localparam int         CLK_PERIOD = 10;
   localparam int         LANES      = 8;
   localparam logic [7:0] MASK       = 8'h66;

   logic             clk = 1'b0;
   logic             por_n, rst_n;
   logic [2:0]       reg_addr;
   logic [7:0]       reg_wdata;
   logic             reg_we;
   logic [7:0]       reg_rdata;
   logic [1:0]       strap_amt;
   logic             strap_ss_en, strap_sscg_path;
   logic [LANES-1:0] oe_pin, out_run;
   logic [1:0]       eff_amt;
   logic             eff_ss_en, eff_sscg_path, pwrdn_hiz, stop_hiz;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   string tag    = "R9";

   // reference model state
   bit       m_cap, m_src;
   bit [3:0] m_fld;
   bit [2:0] m_up;
   bit [7:0] m_b1, m_b2;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkbuf_cfg_regs dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
      .strap_amt(strap_amt), .strap_ss_en(strap_ss_en), .strap_sscg_path(strap_sscg_path),
      .oe_pin(oe_pin), .out_run(out_run),
      .eff_amt(eff_amt), .eff_ss_en(eff_ss_en), .eff_sscg_path(eff_sscg_path),
      .pwrdn_hiz(pwrdn_hiz), .stop_hiz(stop_hiz)
   );

   task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_async();
      if (!por_n) begin
         m_cap = 0; m_src = 1; m_fld = '0;
      end
      if (!por_n || !rst_n) begin
         m_up = '0; m_b1 = 8'hFF; m_b2 = 8'h00;
      end
   endtask

   task automatic model_clock();
      if (por_n && rst_n) begin
         if (!m_cap) begin
            m_cap = 1;
            m_fld = {strap_amt, strap_ss_en, strap_sscg_path};
         end else if (reg_we) begin
            case (reg_addr)
               3'd0: begin
                  m_up = reg_wdata[7:5];
                  if (!m_src || !reg_wdata[0]) m_fld = reg_wdata[4:1];
                  m_src = m_src & reg_wdata[0];
               end
               3'd1: m_b1 = reg_wdata;
               3'd2: m_b2 = reg_wdata;
               default: ;
            endcase
         end
      end
   endtask

   task automatic compare();
      logic [7:0] exp_rd;
      logic [3:0] exp_eff;
      logic [7:0] exp_run;
      case (reg_addr)
         3'd0:    exp_rd = {m_up, m_fld, m_src};
         3'd1:    exp_rd = m_b1;
         3'd2:    exp_rd = m_b2;
         default: exp_rd = 8'h00;
      endcase
      exp_eff = m_src ? {strap_amt, strap_ss_en, strap_sscg_path} : m_fld;
      for (int i = 0; i < LANES; i++)
         exp_run[i] = MASK[i] & m_b1[i] & (~m_b2[i] | oe_pin[i]);
      chk("rdata", reg_rdata, exp_rd);
      chk("eff", {4'h0, eff_amt, eff_ss_en, eff_sscg_path}, {4'h0, exp_eff});
      chk("out_run", out_run, exp_run);
      chk("hiz", {6'h0, pwrdn_hiz, stop_hiz}, {6'h0, m_up[2], m_up[1]});
   endtask

   // inputs were set at a falling edge; compare, then advance one clock
   task automatic tick();
      #1;
      model_async();
      compare();
      @(posedge clk);
      model_clock();
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a);
      reg_addr = a; reg_we = 1'b0;
      tick();
   endtask

   task automatic straps(input logic [1:0] a, input logic s, input logic p);
      strap_amt = a; strap_ss_en = s; strap_sscg_path = p;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      por_n = 0; rst_n = 0; reg_addr = 0; reg_wdata = 0; reg_we = 0;
      oe_pin = '0;
      straps(2'b10, 1'b1, 1'b0);
      @(negedge clk);

      // R9 reset values, R7 hiz after reset
      tag = "R9";
      rd(3'd0); rd(3'd1); rd(3'd2);
      tag = "R7";
      rd(3'd0);

      // R11: write on the capture cycle is ignored; R1 capture itself
      tag = "R11";
      por_n = 1; rst_n = 1;
      wr(3'd1, 8'h00);
      rd(3'd1);
      tag = "R1";
      rd(3'd0);

      // R2 / R3 / R12: straps move; stored value holds, effective follows pins
      tag = "R3";
      straps(2'b01, 1'b0, 1'b1);
      rd(3'd0);
      tag = "R12";
      straps(2'b11, 1'b0, 1'b0);
      rd(3'd0);
      tag = "R2";
      straps(2'b00, 1'b1, 1'b1);
      rd(3'd0);

      // R6: write keeping source on pins
      tag = "R6";
      wr(3'd0, 8'b1011_1111);
      rd(3'd0);
      tag = "R7";
      wr(3'd0, 8'b0100_0001);
      rd(3'd0);

      // R8 gating patterns
      tag = "R8";
      wr(3'd1, 8'h62);
      wr(3'd2, 8'h60);
      oe_pin = 8'h00; rd(3'd1);
      oe_pin = 8'hFF; rd(3'd2);
      oe_pin = 8'h20; rd(3'd1);
      wr(3'd2, 8'h00); oe_pin = 8'h00; rd(3'd2);

      // R9 warm reset; R2 no recapture
      tag = "R9";
      wr(3'd1, 8'h5A);
      wr(3'd2, 8'hA5);
      rd(3'd1); rd(3'd2);
      rst_n = 0;
      straps(2'b11, 1'b1, 1'b1);
      rd(3'd1); rd(3'd2);
      rst_n = 1;
      tag = "R2";
      rd(3'd0); rd(3'd0);
      tag = "R9";
      rd(3'd1); rd(3'd2);

      // R4 handover write carries the field
      tag = "R4";
      wr(3'd0, 8'b0000_1100);
      straps(2'b00, 1'b0, 1'b1);
      rd(3'd0);
      straps(2'b10, 1'b1, 1'b0);
      rd(3'd0);

      // R5 source bit sticky
      tag = "R5";
      wr(3'd0, 8'b0001_0111);
      rd(3'd0);
      rst_n = 0; rd(3'd0); rst_n = 1; rd(3'd0);

      // R10 unmapped addresses
      tag = "R10";
      wr(3'd3, 8'hAA);
      rd(3'd3);
      wr(3'd7, 8'h55);
      rd(3'd7); rd(3'd1); rd(3'd0);

      // R1 / R11 again after a new power-on
      tag = "R1";
      por_n = 0; rst_n = 0;
      straps(2'b01, 1'b1, 1'b1);
      rd(3'd0);
      por_n = 1; rst_n = 1;
      tag = "R11";
      wr(3'd0, 8'h00);
      tag = "R1";
      rd(3'd0);

      // mixed traffic against the model
      tag = "R8";
      for (int n = 0; n < 600; n++) begin
         por_n     = ($urandom_range(0, 199) != 0);
         rst_n     = ($urandom_range(0, 79) != 0);
         reg_addr  = 3'($urandom_range(0, 7));
         reg_we    = ($urandom_range(0, 2) == 0);
         reg_wdata = 8'($urandom);
         if ($urandom_range(0, 3) != 0) reg_wdata[0] = 1'b1;
         oe_pin    = 8'($urandom);
         straps(2'($urandom), 1'($urandom), 1'($urandom));
         tick();
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule